// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This controller sits between a synchronous host port and an external asynchronous static RAM made of two 8-bit byte lanes that share a 19-bit address. Each host request is turned into a complete bus cycle. The controller drives the address, a chip enable and a write enable for each lane, a shared output enable, and a split data bus made of a drive value, a drive enable and a sampled input. The pulse, setup and recovery lengths are whole clock counts. They are derived at elaboration from nanosecond minimums and a clock-period parameter, and each is rounded up to the next edge.

The host sees a request/ready handshake. A request is taken only while the controller is idle. A write needs no response. A read returns its data with a one-cycle valid pulse. The array can be used as 512K 16-bit words or, through a byte-mode flag, as a 1M x 8 space. In byte mode the lowest host address bit picks the lane, and only that lane's chip enable is asserted.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is 1, all chip enables and write enables are high, `mem_oe_n` is high and `mem_dq_oe` is 0.
- R2: A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance, and requests presented while it is 0 have no effect on memory contents.
- R3: In a write, the chip enable is low for at least AS = ceil(T_AS/CLK) cycles before the write enable falls. The write enable stays low for exactly max(ceil(T_WP/CLK), ceil(T_DW/CLK)) cycles. It rises at least one cycle before the chip enable rises. The chip enable stays low for at least ceil(T_WC/CLK) cycles.
- R4: While `mem_dq_oe` is 1, the address, the drive data and the chip enables are stable.
- R5: `mem_oe_n` is never low while `mem_dq_oe` is 1, and `mem_dq_oe` is 0 in the cycle before `mem_oe_n` falls.
- R6: A read holds `mem_oe_n` low for max(ceil(T_AA/CLK)-1, ceil(T_OE/CLK)) cycles after a single turnaround cycle. The data is sampled on the last of those cycles. `rsp_valid` is 1 for exactly one cycle, 2 + that count cycles after the accepting edge.
- R7: `req_byte` = 1 selects byte mode. Host address bit 0 = 0 selects the lower lane (index 0, data bits 7:0) and 1 selects the upper lane (index 1, data bits 15:8). Only the selected lane's chip enable and write enable go low. `mem_addr` is always host address bits 19:1.
- R8: A byte write stores `req_wdata[7:0]` into the selected lane and leaves the other lane's byte unchanged.
- R9: A byte read returns the selected lane's byte in `rsp_rdata[7:0]` with bits 15:8 zero.
- R10: With `req_byte` = 0 both lanes are enabled, host address bit 0 is ignored, and the word maps lower lane to bits 7:0 and upper lane to bits 15:8.
- R11: A write enable is low only while its own lane's chip enable is low, and never while `mem_oe_n` is low.
- R12: With the default 10 ns clock and the 17/2/13/25/25/12 ns minimums, a write occupies 4 bus cycles, the write enable is low for 2 cycles, and a read responds 4 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single-byte access, 0 = 16-bit access |
| req_addr | input | 20 | Host byte address; bit 0 picks the lane in byte mode |
| req_wdata | input | 16 | Write data; bits 7:0 only in byte mode |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 19 | SRAM address |
| mem_ce_n | output | 2 | Per-lane chip enable, active low |
| mem_we_n | output | 2 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 16 | Data driven toward the SRAM |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 16 | Data sampled from the SRAM |

## Verification
The assertions assume the memory side only returns data and never forces the enables. They also assume the host keeps a request's fields steady from the cycle it raises `req_valid` until acceptance. The bench drives requests only at falling edges, holds every field until the accepting edge and then drops `req_valid`. The one exception is a deliberate burst of `req_valid` that is raised only while `req_ready` is seen low and lowered before it can be accepted. Random addresses come from a small pool spread over the full 20-bit range, so reads often hit addresses written earlier in both word and byte modes.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM bus controller.
// Assumes all timing inputs are non-negative nanosecond values.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_TURN,
        ST_RD_WAIT
    } bus_state_t;

    // Whole clock cycles that cover a minimum time, never fewer than one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counting wait-state timer. Loading a count N makes done true
// after N-1 further cycles, so the current state lasts N cycles.
// Assumes load_val is at least 1.
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_sel.sv
// Maps a host request onto the two byte lanes: lane mask, word address
// and the data pattern placed on the bus. Purely combinational.
// Assumes the host address is a byte address with the lane in bit 0.
module sram_lane_sel #(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8
) (
    input  logic                  byte_mode,
    input  logic [ADDR_W:0]       host_addr,
    input  logic [2*LANE_W-1:0]   host_wdata,
    output logic [1:0]            lane_en,
    output logic [ADDR_W-1:0]     word_addr,
    output logic [2*LANE_W-1:0]   bus_wdata
);
    // Lane mask and bus data: both lanes for a word, one lane for a byte.
    always_comb begin
        word_addr = host_addr[ADDR_W:1];
        if (byte_mode) begin
            lane_en   = host_addr[0] ? 2'b10 : 2'b01;
            bus_wdata = {host_wdata[LANE_W-1:0], host_wdata[LANE_W-1:0]};
        end else begin
            lane_en   = 2'b11;
            bus_wdata = host_wdata;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
// Samples the SRAM data bus at the end of the output-enable window and
// issues a one-cycle valid pulse with the lane-aligned result.
// Assumes capture is asserted for a single cycle per read.
module sram_rd_capture #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                byte_mode,
    input  logic                lane_hi,
    input  logic [2*LANE_W-1:0] bus_rdata,
    output logic                rd_valid,
    output logic [2*LANE_W-1:0] rd_data
);
    // Register read data and produce the single-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                if (!byte_mode)
                    rd_data <= bus_rdata;
                else if (lane_hi)
                    rd_data <= {{LANE_W{1'b0}}, bus_rdata[2*LANE_W-1:LANE_W]};
                else
                    rd_data <= {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
// Synchronous controller producing asynchronous SRAM read and write
// cycles for two byte lanes. Wait states come from nanosecond minimums
// rounded up to whole clock periods of CLK_NS. Bus controls are decoded
// from registered state; the SRAM is assumed to tolerate that decode.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8,
    parameter int CLK_NS = 10,
    parameter int T_AS_NS = 2,
    parameter int T_WP_NS = 17,
    parameter int T_DW_NS = 13,
    parameter int T_WC_NS = 25,
    parameter int T_AA_NS = 25,
    parameter int T_OE_NS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_byte,
    input  logic [ADDR_W:0]      req_addr,
    input  logic [2*LANE_W-1:0]  req_wdata,
    output logic                 rsp_valid,
    output logic [2*LANE_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [1:0]           mem_ce_n,
    output logic [1:0]           mem_we_n,
    output logic                 mem_oe_n,
    output logic [2*LANE_W-1:0]  mem_dq_o,
    output logic                 mem_dq_oe,
    input  logic [2*LANE_W-1:0]  mem_dq_i
);
    localparam int DQ_W   = 2 * LANE_W;
    localparam int AS_C   = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int WP_C   = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int REC_C  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - AS_C - WP_C);
    localparam int RD_C   = imax(ns_to_cyc(T_AA_NS, CLK_NS) - 1, ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int MAX_C  = imax(imax(AS_C, WP_C), imax(REC_C, RD_C));
    localparam int CNT_W  = $clog2(MAX_C + 1);

    bus_state_t          state_q, state_d;
    logic [1:0]          lane_q, lane_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [DQ_W-1:0]     wdat_q, wdat_d;
    logic                byte_q, lanehi_q;
    logic                tmr_load, tmr_done, rd_capture;
    logic [CNT_W-1:0]    tmr_val;
    logic                accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_lane_sel #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
        .byte_mode (req_byte),
        .host_addr (req_addr),
        .host_wdata(req_wdata),
        .lane_en   (lane_d),
        .word_addr (addr_d),
        .bus_wdata (wdat_d)
    );

    sram_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    sram_rd_capture #(.LANE_W(LANE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .byte_mode(byte_q),
        .lane_hi  (lanehi_q),
        .bus_rdata(mem_dq_i),
        .rd_valid (rsp_valid),
        .rd_data  (rsp_rdata)
    );

    // Next-state, timer reload and read-capture decisions.
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = CNT_W'(1);
        rd_capture = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                if (req_write) begin
                    state_d  = ST_WR_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(AS_C);
                end else begin
                    state_d  = ST_RD_TURN;
                end
            end
            ST_WR_SETUP: if (tmr_done) begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_C);
            end
            ST_WR_PULSE: if (tmr_done) begin
                state_d  = ST_WR_RECOV;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_C);
            end
            ST_WR_RECOV: if (tmr_done) state_d = ST_IDLE;
            ST_RD_TURN: begin
                state_d  = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_C);
            end
            ST_RD_WAIT: if (tmr_done) begin
                state_d    = ST_IDLE;
                rd_capture = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latches taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lane_q   <= 2'b00;
            addr_q   <= '0;
            wdat_q   <= '0;
            byte_q   <= 1'b0;
            lanehi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lane_q   <= lane_d;
                addr_q   <= addr_d;
                wdat_q   <= wdat_d;
                byte_q   <= req_byte;
                lanehi_q <= req_addr[0];
            end
        end
    end

    // Bus control decode from the registered state.
    always_comb begin
        mem_addr  = addr_q;
        mem_dq_o  = wdat_q;
        mem_ce_n  = (state_q == ST_IDLE) ? 2'b11 : ~lane_q;
        mem_we_n  = (state_q == ST_WR_PULSE) ? ~lane_q : 2'b11;
        mem_oe_n  = (state_q != ST_RD_WAIT);
        mem_dq_oe = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE) ||
                    (state_q == ST_WR_RECOV);
    end
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for sram_bus_ctrl, attached by bind. Observes ports only.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [1:0]          mem_ce_n,
    input logic [1:0]          mem_we_n,
    input logic                mem_oe_n,
    input logic [2*LANE_W-1:0] mem_dq_o,
    input logic                mem_dq_oe
);
    // R1
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !mem_dq_oe));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    we_fall_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_n != 2'b11) && ($past(mem_we_n) == 2'b11)) |-> ($past(mem_ce_n) == mem_ce_n));

    // R3
    ce_rise_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_ce_n == 2'b11) && ($past(mem_ce_n) != 2'b11)) |-> ($past(mem_we_n) == 2'b11));

    // R4
    write_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_ce_n)));

    // R5
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R5
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R6
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> !$past(mem_oe_n));

    // R11
    we_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mem_we_n) & mem_ce_n) == 2'b00);

    // R11
    we_oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((mem_we_n != 2'b11) && !mem_oe_n));
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bus_ctrl_tb.sv
// Bench for sram_bus_ctrl with a behavioural two-lane SRAM stub.
module sram_bus_ctrl_tb;
    localparam int CLK_NS = 10;
    function automatic int cdiv(input int t);
        int c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int EXP_AS  = cdiv(2);
    localparam int EXP_WP  = (cdiv(17) > cdiv(13)) ? cdiv(17) : cdiv(13);
    localparam int EXP_WC  = cdiv(25);
    localparam int EXP_RD  = ((cdiv(25) - 1) > cdiv(12)) ? (cdiv(25) - 1) : cdiv(12);
    localparam int EXP_LAT = 2 + EXP_RD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mem_oe_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [18:0] mem_addr;
    logic [1:0]  mem_ce_n, mem_we_n;

    int n_chk = 0, n_bad = 0;
    logic [1:0] exp_lanes = 2'b11;

    always #5 clk = ~clk;

    sram_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // ---- SRAM stub: contents default to an address-derived pattern ----
    logic [7:0] st_lo [int];
    logic [7:0] st_hi [int];
    function automatic logic [7:0] dflt(input bit hi, input int a);
        return hi ? (8'(a >> 3) ^ 8'hA5) : (8'(a) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] stub_rd(input bit hi, input int a);
        if (hi) return st_hi.exists(a) ? st_hi[a] : dflt(1'b1, a);
        return st_lo.exists(a) ? st_lo[a] : dflt(1'b0, a);
    endfunction
    always @(posedge clk) begin
        if (!mem_ce_n[0] && !mem_we_n[0]) st_lo[int'(mem_addr)] = mem_dq_o[7:0];
        if (!mem_ce_n[1] && !mem_we_n[1]) st_hi[int'(mem_addr)] = mem_dq_o[15:8];
    end
    assign mem_dq_i[7:0]  = (!mem_ce_n[0] && !mem_oe_n && mem_we_n[0]) ? stub_rd(1'b0, int'(mem_addr)) : 8'hEE;
    assign mem_dq_i[15:8] = (!mem_ce_n[1] && !mem_oe_n && mem_we_n[1]) ? stub_rd(1'b1, int'(mem_addr)) : 8'hEE;

    // ---- shadow model from the requirements ----
    logic [7:0] sh_lo [int];
    logic [7:0] sh_hi [int];
    function automatic logic [15:0] exp_read(input bit byt, input logic [19:0] a);
        int w;
        logic [7:0] lo, hi;
        w  = int'(a[19:1]);
        lo = sh_lo.exists(w) ? sh_lo[w] : dflt(1'b0, w);
        hi = sh_hi.exists(w) ? sh_hi[w] : dflt(1'b1, w);
        if (!byt) return {hi, lo};
        return a[0] ? {8'h00, hi} : {8'h00, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---- bus timing monitor (R3, R5, R7, R10, R11, R12) ----
    logic [1:0] prev_we = 2'b11, prev_ce = 2'b11;
    logic prev_oe = 1'b1, prev_dqoe = 1'b0, was_wr = 1'b0;
    int ce_cnt = 0, we_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && prev_oe)
                chk(!mem_dq_oe && !prev_dqoe, "R5 turnaround", {mem_dq_oe, prev_dqoe}, 0);
            if (mem_ce_n != 2'b11) begin
                if (mem_we_n != 2'b11 && prev_we == 2'b11) begin
                    chk(ce_cnt >= EXP_AS, "R3 setup cycles", ce_cnt, EXP_AS);
                    chk(mem_we_n == ~exp_lanes, "R7/R10 lane we", mem_we_n, ~exp_lanes);
                    chk(mem_ce_n == mem_we_n && mem_oe_n, "R11 we/ce/oe", {mem_oe_n, mem_ce_n}, {1'b1, mem_we_n});
                    was_wr = 1'b1;
                end
                if (mem_we_n == 2'b11 && prev_we != 2'b11)
                    chk(we_cnt == EXP_WP, "R3 R12 pulse cycles", we_cnt, EXP_WP);
                ce_cnt++;
                we_cnt = (mem_we_n != 2'b11) ? we_cnt + 1 : 0;
            end else if (prev_ce != 2'b11) begin
                if (was_wr) begin
                    chk(ce_cnt >= EXP_WC && prev_we == 2'b11, "R3 cycle/recovery", ce_cnt, EXP_WC);
                    chk(ce_cnt == EXP_AS + EXP_WP + 1, "R12 write length", ce_cnt, EXP_AS + EXP_WP + 1);
                end
                was_wr = 1'b0;
                ce_cnt = 0;
                we_cnt = 0;
            end
            prev_we = mem_we_n; prev_ce = mem_ce_n;
            prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
        end
    end

    // Issue one request; returns read data and latency in cycles.
    task automatic issue(input bit wr, input bit byt, input logic [19:0] a,
                         input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_lanes = byt ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
        req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        lat = 1;
        rd = '0;
        if (!wr) begin
            while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
            rd = rsp_rdata;
            @(negedge clk);
            chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
        end
    endtask

    task automatic do_write(input bit byt, input logic [19:0] a, input logic [15:0] d);
        logic [15:0] rd;
        int lat, w;
        issue(1'b1, byt, a, d, rd, lat);
        w = int'(a[19:1]);
        if (!byt) begin sh_lo[w] = d[7:0]; sh_hi[w] = d[15:8]; end
        else if (a[0]) sh_hi[w] = d[7:0];
        else sh_lo[w] = d[7:0];
    endtask

    task automatic do_read(input bit byt, input logic [19:0] a, input string req);
        logic [15:0] rd, ex;
        int lat;
        ex = exp_read(byt, a);
        issue(1'b0, byt, a, 16'h0, rd, lat);
        chk(rd == ex, req, rd, ex);
        chk(lat == EXP_LAT, "R6 R12 read latency", lat, EXP_LAT);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int lat;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        chk(mem_ce_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !mem_dq_oe,
            "R1 in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b111110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n == 2'b11 && !rsp_valid, "R1 after reset",
            {req_ready, mem_ce_n, rsp_valid}, 4'b1110);

        // Word write/read, including address bit 0 ignored (R10).
        do_write(1'b0, 20'h00010, 16'hBEEF);
        do_read(1'b0, 20'h00010, "R10 word read");
        do_read(1'b0, 20'h00011, "R10 bit0 ignored");
        chk(mem_addr == 19'h00008, "R7 word address", mem_addr, 19'h00008);
        // Byte writes to each lane (R7, R8) then word read back.
        do_write(1'b1, 20'hFFFFE, 16'h1234);
        do_write(1'b1, 20'hFFFFF, 16'h5678);
        do_read(1'b0, 20'hFFFFE, "R8 byte lanes merge");
        do_write(1'b1, 20'h00011, 16'hFFC3);
        do_read(1'b0, 20'h00010, "R8 other lane kept");
        do_read(1'b1, 20'h00011, "R9 upper byte read");
        do_read(1'b1, 20'h00010, "R9 lower byte read");
        do_read(1'b1, 20'h0ABCD, "R9 unwritten byte");

        // R2: requests offered while busy are ignored.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_lanes = 2'b11;
        req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b0;
        req_addr = 20'h00100; req_wdata = 16'hA1A1;
        @(negedge clk);
        req_addr = 20'h00200; req_wdata = 16'hDEAD;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        sh_lo[int'(20'h00080)] = 8'hA1; sh_hi[int'(20'h00080)] = 8'hA1;
        do_read(1'b0, 20'h00200, "R2 busy request ignored");
        do_read(1'b0, 20'h00100, "R2 accepted write");

        // Constrained random mix.
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            bit wr, byt;
            a   = 20'($urandom_range(0, 15) * 32'h0F3D7);
            wr  = $urandom_range(0, 1) == 1;
            byt = $urandom_range(0, 2) == 0;
            if (wr) do_write(byt, a, 16'($urandom));
            else    do_read(byt, a, byt ? "R9 random byte read" : "R10 random word read");
        end

        issue(1'b0, 1'b0, 20'h0, 16'h0, rd, lat);
        @(negedge clk);
        chk(req_ready && mem_oe_n, "R1 idle at end", {req_ready, mem_oe_n}, 2'b11);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule